// File: doc/BRIEF.md
# Audio Sample FIFO with Coded Attention Thresholds

A 16-entry, 32-bit sample queue that sits between a digital audio serial engine and a bus. The same module is built twice: once for the playback direction, where the bus fills it and the serial shifter drains it, and once for the capture direction, where the shifter fills it and the bus drains it. A parameter picks the direction.

Software sees one control/status word. Writing it selects a 2-bit attention-level code, can empty the queue, can clear the sticky error bit, and sets two separate interrupt enables. Reading it returns the fill count, the level code, the attention flag, the error flag and the enables. The count shows free slots on the playback side and occupied slots on the capture side. Attention is raised when that count reaches the threshold the code selects. The error flag records an underrun on the playback side and an overrun on the capture side.

Top module: `snd_sample_fifo`

## Requirements
- R1: After reset the queue is empty, the level code is 0, both enables and the error flag are 0, and irq is 0. The capture status word reads 0x000. The playback status word reads 0x090, which is a count of 16 with attention set.
- R2: Pushed words come out in push order. pop_data always shows the oldest stored word, and an accepted pop advances to the next one.
- R3: Status bits [4:0] hold the count. On capture (IS_TX=0) this is the number of occupied entries; on playback (IS_TX=1) it is DEPTH minus that number.
- R4: The level code is written from wdata[1:0] and read back at status bits [6:5]. Code 0 selects a threshold of 1 slot, code 1 selects 4, code 2 selects 8 and code 3 selects 12. Status bit 7 (attention) is 1 exactly when the count is at or above the selected threshold.
- R5: A status-word write with wdata[2]=1 empties the queue. It takes priority over a push or pop in the same cycle, and that push or pop has no effect.
- R6: On playback, a pop while empty sets the error flag (status bit 8). On capture, a push while full sets the error flag, the word is dropped, and the stored words are unchanged.
- R7: The error flag stays set until a status-word write with wdata[3]=1 clears it. If an error occurs in the same cycle as that clear, the flag stays set.
- R8: The attention enable is written from wdata[4] and read at status bit 9. The error enable is written from wdata[5] and read at status bit 10. irq equals (attention AND its enable) OR (error AND its enable).
- R9: On playback, a push while full is dropped without setting the error flag. On capture, a pop while empty does nothing and does not set the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push | input | 1 | Write a word into the queue |
| push_data | input | 32 | Word to write |
| full | output | 1 | All entries occupied |
| pop | input | 1 | Remove the oldest word |
| pop_data | output | 32 | Oldest stored word |
| empty | output | 1 | No entries occupied |
| csr_wr | input | 1 | Status-word write strobe |
| csr_wdata | input | 6 | [1:0] level code, [2] empty queue, [3] clear error, [4] attention enable, [5] error enable |
| csr_rdata | output | 11 | [4:0] count, [6:5] level, [7] attention, [8] error, [9] attention enable, [10] error enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the module twice at the default depth of 16: once with IS_TX=0 and once with IS_TX=1. Both count conventions and both error sources are therefore exercised side by side. A depth of 16 makes the full and empty edges reachable in a few dozen cycles, and it lets the count sit on every threshold (1, 4, 8, 12) and one slot below each. The table walks each level code at and just under its threshold. The directed tests push into a full queue, pop from an empty one, and collide a clear with a push.

// File: rtl/snd_fifo_pkg.sv
package snd_fifo_pkg;

    // control word written by software
    localparam int CSR_WR_W       = 6;
    localparam int CSR_LVL_LSB    = 0;
    localparam int CSR_FLUSH_BIT  = 2;
    localparam int CSR_ERRCLR_BIT = 3;
    localparam int CSR_AIE_BIT    = 4;
    localparam int CSR_EIE_BIT    = 5;

    typedef enum logic [1:0] {
        LVL_ONE    = 2'd0,
        LVL_FOUR   = 2'd1,
        LVL_EIGHT  = 2'd2,
        LVL_TWELVE = 2'd3
    } lvl_code_e;

    function automatic int lvl_slots(lvl_code_e code);
        case (code)
            LVL_ONE:   return 1;
            LVL_FOUR:  return 4;
            LVL_EIGHT: return 8;
            default:   return 12;
        endcase
    endfunction

endpackage

// File: rtl/snd_fifo_store.sv
module snd_fifo_store #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [OCC_W-1:0] occ,
    output logic             full,
    output logic             empty,
    output logic             push_rej,
    output logic             pop_rej
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wp;
        logic [PTR_W-1:0]            rp;
        logic [OCC_W-1:0]            occ;
    } store_t;

    store_t st_d, st_q;
    logic   do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full     = (st_q.occ == OCC_W'(DEPTH));
        empty    = (st_q.occ == '0);
        do_push  = push && !full && !flush;
        do_pop   = pop && !empty && !flush;
        push_rej = push && full && !flush;
        pop_rej  = pop && empty && !flush;

        st_d = st_q;
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.occ = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wp] = push_data;
                st_d.wp           = bump(st_q.wp);
            end
            if (do_pop) begin
                st_d.rp = bump(st_q.rp);
            end
            case ({do_push, do_pop})
                2'b10:   st_d.occ = st_q.occ + 1'b1;
                2'b01:   st_d.occ = st_q.occ - 1'b1;
                default: st_d.occ = st_q.occ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head = st_q.mem[st_q.rp];
    assign occ  = st_q.occ;

    // R3
    occ_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.occ <= OCC_W'(DEPTH));

    // R5
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occ == '0));

    // R2
    push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop && !flush) |=> (occ == $past(occ) + 1'b1));

    // R6
    full_push_keeps_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> $stable(head));

endmodule

// File: rtl/snd_fifo_status.sv
module snd_fifo_status
    import snd_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter bit IS_TX = 1'b0,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                csr_wr,
    input  logic [CSR_WR_W-1:0] csr_wdata,
    input  logic [OCC_W-1:0]    occ,
    input  logic                err_evt,
    output lvl_code_e           level,
    output logic [OCC_W-1:0]    count,
    output logic                attn,
    output logic                err,
    output logic                aie,
    output logic                eie,
    output logic                irq
);
    typedef struct packed {
        lvl_code_e lvl;
        logic      aie;
        logic      eie;
        logic      err;
    } stat_t;

    stat_t st_d, st_q;

    generate
        if (IS_TX) begin : g_free
            assign count = OCC_W'(DEPTH) - occ;
        end else begin : g_used
            assign count = occ;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (csr_wr) begin
            st_d.lvl = lvl_code_e'(csr_wdata[CSR_LVL_LSB +: 2]);
            st_d.aie = csr_wdata[CSR_AIE_BIT];
            st_d.eie = csr_wdata[CSR_EIE_BIT];
            if (csr_wdata[CSR_ERRCLR_BIT]) st_d.err = 1'b0;
        end
        if (err_evt) st_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lvl: LVL_ONE, aie: 1'b0, eie: 1'b0, err: 1'b0};
        else        st_q <= st_d;
    end

    always_comb begin
        level = st_q.lvl;
        aie   = st_q.aie;
        eie   = st_q.eie;
        err   = st_q.err;
        attn  = (int'(count) >= lvl_slots(st_q.lvl));
        irq   = (attn && st_q.aie) || (st_q.err && st_q.eie);
    end

    // R6
    err_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> err);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(csr_wr && csr_wdata[CSR_ERRCLR_BIT])) |=> err);

    // R8
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (aie || eie));

    // R4
    attn_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !attn);

endmodule

// File: rtl/snd_sample_fifo.sv
module snd_sample_fifo
    import snd_fifo_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    parameter bit IS_TX = 1'b0,
    localparam int OCC_W  = $clog2(DEPTH + 1),
    localparam int RD_LVL = OCC_W,
    localparam int RD_ATN = OCC_W + 2,
    localparam int RD_ERR = OCC_W + 3,
    localparam int RD_AIE = OCC_W + 4,
    localparam int RD_EIE = OCC_W + 5,
    localparam int RD_W   = OCC_W + 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  logic [WIDTH-1:0]    push_data,
    output logic                full,
    input  logic                pop,
    output logic [WIDTH-1:0]    pop_data,
    output logic                empty,
    input  logic                csr_wr,
    input  logic [CSR_WR_W-1:0] csr_wdata,
    output logic [RD_W-1:0]     csr_rdata,
    output logic                irq
);
    logic             flush, push_rej, pop_rej, err_evt;
    logic [OCC_W-1:0] occ, count;
    lvl_code_e        level;
    logic             attn, err, aie, eie;

    assign flush   = csr_wr && csr_wdata[CSR_FLUSH_BIT];
    assign err_evt = IS_TX ? pop_rej : push_rej;

    snd_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(push), .push_data(push_data), .pop(pop),
        .head(pop_data), .occ(occ), .full(full), .empty(empty),
        .push_rej(push_rej), .pop_rej(pop_rej)
    );

    snd_fifo_status #(.DEPTH(DEPTH), .IS_TX(IS_TX)) u_status (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .occ(occ), .err_evt(err_evt), .level(level), .count(count),
        .attn(attn), .err(err), .aie(aie), .eie(eie), .irq(irq)
    );

    always_comb begin
        csr_rdata                 = '0;
        csr_rdata[OCC_W-1:0]      = count;
        csr_rdata[RD_LVL +: 2]    = level;
        csr_rdata[RD_ATN]         = attn;
        csr_rdata[RD_ERR]         = err;
        csr_rdata[RD_AIE]         = aie;
        csr_rdata[RD_EIE]         = eie;
    end

endmodule

// File: tb/sim_snd_sample_fifo.sv
module sim_snd_sample_fifo;
    logic clk = 0;
    logic rst_n = 0;
    always #5 clk = ~clk;

    logic        r_push = 0, r_pop = 0, r_wr = 0, r_full, r_empty, r_irq;
    logic [31:0] r_pd = 0, r_head;
    logic [5:0]  r_wd = 0;
    logic [10:0] r_st;
    logic        t_push = 0, t_pop = 0, t_wr = 0, t_full, t_empty, t_irq;
    logic [31:0] t_pd = 0, t_head;
    logic [5:0]  t_wd = 0;
    logic [10:0] t_st;

    snd_sample_fifo #(.IS_TX(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .push(r_push), .push_data(r_pd), .full(r_full),
        .pop(r_pop), .pop_data(r_head), .empty(r_empty), .csr_wr(r_wr),
        .csr_wdata(r_wd), .csr_rdata(r_st), .irq(r_irq));

    snd_sample_fifo #(.IS_TX(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .push(t_push), .push_data(t_pd), .full(t_full),
        .pop(t_pop), .pop_data(t_head), .empty(t_empty), .csr_wr(t_wr),
        .csr_wdata(t_wd), .csr_rdata(t_st), .irq(t_irq));

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rx(logic pu, logic [31:0] d, logic po, logic wr, logic [5:0] wd);
        r_push = pu; r_pd = d; r_pop = po; r_wr = wr; r_wd = wd;
        @(negedge clk);
        r_push = 0; r_pop = 0; r_wr = 0;
    endtask

    task automatic tx(logic pu, logic [31:0] d, logic po, logic wr, logic [5:0] wd);
        t_push = pu; t_pd = d; t_pop = po; t_wr = wr; t_wd = wd;
        @(negedge clk);
        t_push = 0; t_pop = 0; t_wr = 0;
    endtask

    // {pushes, level code, expected count, expected attention}
    typedef struct packed { logic [4:0] n; logic [1:0] lvl; logic [4:0] cnt; logic atn; } vec_t;
    localparam vec_t VECS [9] = '{
        '{5'd0,  2'd0, 5'd0,  1'b0}, '{5'd1,  2'd0, 5'd1,  1'b1},
        '{5'd3,  2'd1, 5'd3,  1'b0}, '{5'd4,  2'd1, 5'd4,  1'b1},
        '{5'd7,  2'd2, 5'd7,  1'b0}, '{5'd8,  2'd2, 5'd8,  1'b1},
        '{5'd11, 2'd3, 5'd11, 1'b0}, '{5'd12, 2'd3, 5'd12, 1'b1},
        '{5'd16, 2'd3, 5'd16, 1'b1}};

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 rx status", 32'(r_st), 32'h000);
        check("R1 tx status", 32'(t_st), 32'h090);
        check("R1 irq", {30'd0, r_irq, t_irq}, 32'd0);

        // R3 R4 table of fill and level code
        foreach (VECS[k]) begin
            rx(0, 0, 0, 1, 6'h04);
            for (int i = 0; i < int'(VECS[k].n); i++) rx(1, 32'hA000_0000 + i, 0, 0, 0);
            rx(0, 0, 0, 1, {4'd0, VECS[k].lvl});
            check("R3 rx count", 32'(r_st[4:0]), 32'(VECS[k].cnt));
            check("R4 attention", 32'(r_st[7]), 32'(VECS[k].atn));
            check("R4 level readback", 32'(r_st[6:5]), 32'(VECS[k].lvl));
        end

        // R6 overrun on full capture queue
        rx(1, 32'hDEAD_BEEF, 0, 0, 0);
        check("R6 overrun err", 32'(r_st[8]), 32'd1);
        check("R6 count held", 32'(r_st[4:0]), 32'd16);
        check("R6 head kept", r_head, 32'hA000_0000);
        check("R8 irq masked", 32'(r_irq), 32'd0);
        rx(0, 0, 0, 1, 6'h23);
        check("R8 err irq", 32'(r_irq), 32'd1);
        // R7 set wins over clear in same cycle
        rx(1, 32'hDEAD_BEEF, 0, 1, 6'h2B);
        check("R7 set wins", 32'(r_st[8]), 32'd1);
        for (int i = 0; i < 15; i++) rx(0, 0, 1, 0, 0);
        check("R6 dropped word", r_head, 32'hA000_000F);
        check("R7 sticky", 32'(r_st[8]), 32'd1);
        rx(0, 0, 0, 1, 6'h08);
        check("R7 cleared", 32'(r_st[8]), 32'd0);
        check("R8 no irq", 32'(r_irq), 32'd0);
        rx(0, 0, 0, 1, 6'h10);
        check("R8 attn irq", 32'(r_irq), 32'd1);
        rx(0, 0, 1, 0, 0);
        rx(0, 0, 1, 0, 0);
        // R9 pop of empty capture queue
        check("R9 rx empty pop err", 32'(r_st[8]), 32'd0);
        check("R9 rx count", 32'(r_st[4:0]), 32'd0);
        check("R8 irq drops", 32'(r_irq), 32'd0);

        // R2 order
        rx(1, 32'h1111, 0, 0, 0);
        rx(1, 32'h2222, 0, 0, 0);
        rx(1, 32'h3333, 0, 0, 0);
        check("R2 first", r_head, 32'h1111);
        rx(0, 0, 1, 0, 0);
        check("R2 second", r_head, 32'h2222);
        rx(0, 0, 1, 0, 0);
        check("R2 third", r_head, 32'h3333);
        // R5 clear beats push
        rx(1, 32'h4444, 0, 1, 6'h04);
        check("R5 clear count", 32'(r_st[4:0]), 32'd0);
        check("R5 empty", 32'(r_empty), 32'd1);

        // playback side
        for (int i = 0; i < 5; i++) tx(1, 32'hB0 + i, 0, 0, 0);
        check("R3 tx free", 32'(t_st[4:0]), 32'd11);
        tx(0, 0, 0, 1, 6'h03);
        check("R4 tx below", 32'(t_st[7]), 32'd0);
        check("R2 tx head", t_head, 32'hB0);
        tx(0, 0, 1, 0, 0);
        check("R4 tx at 12", 32'(t_st[7]), 32'd1);
        tx(0, 0, 0, 1, 6'h04);
        check("R5 tx free", 32'(t_st[4:0]), 32'd16);
        tx(0, 0, 1, 0, 0);
        check("R6 underrun", 32'(t_st[8]), 32'd1);
        tx(0, 0, 0, 1, 6'h08);
        for (int i = 0; i < 16; i++) tx(1, i, 0, 0, 0);
        check("R9 tx full", 32'(t_full), 32'd1);
        tx(1, 32'h99, 0, 0, 0);
        check("R9 tx no err", 32'(t_st[8]), 32'd0);
        check("R9 tx free 0", 32'(t_st[4:0]), 32'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule